// File: doc/BRIEF.md
# Fractional Delay Tracker for Buffer Readout

This block follows a slowly drifting delay while words are read out of a sample buffer. Each buffer word carries six 3-bit samples, so the readout runs in slots of six clocks. The delay is split into two parts. The coarse part is the word address. The fine part is the clock, within a six-clock slot, at which the word is loaded into the parallel-to-serial output register.

A start pulse captures three values: a 32-bit initial delay, an 18-bit signed drift rate and a start address. On every later clock the rate is added to a 29-bit fraction. A carry out of the fraction, or a borrow from it, moves a 0..5 phase counter that sits above the fraction. When that phase rolls past either end, the address correction fires. For a growing delay the address stays put for one slot. For a shrinking delay it jumps by two words.

No sample data passes through the block, so there is no valid/ready stream and back-pressure does not apply. Every pin is a plain level or pulse. The start address and the phase are taken from the start pulse. The rate must be small enough that the phase moves at most once per slot, which the 18-bit rate against the 29-bit fraction ensures.

Top module: `delay_tracker`

## Requirements
- R1: After reset and until the first start pulse, `tracking`, `load_stb`, `addr_held` and `addr_skipped` are 0, and `rd_addr` and `fine_phase` are 0.
- R2: The clock edge that samples `frame_start` high sets `tracking` to 1 and `rd_addr` to `start_addr`. It sets `fine_phase` to `init_delay[31:29]` reduced modulo 6 (6 gives 0, 7 gives 1) and clears `addr_held` and `addr_skipped`. A start pulse while tracking restarts everything the same way.
- R3: The fraction starts at `init_delay[28:0]`. At each edge after the start edge, the sign-extended two's-complement `delay_rate` is added to it. A carry out of bit 28 raises the phase by one, and a borrow lowers it by one, both modulo 6.
- R4: Slots are six clocks long and are counted from the start edge. `fine_phase` holds the phase value at the start of the slot for the whole slot. `load_stb` is high exactly once per slot, in the cycle whose offset within the slot equals `fine_phase`.
- R5: A phase rollover from 5 to 0 (positive rate) during a slot makes the next slot keep the same `rd_addr`. `addr_held` is high for that next slot.
- R6: A phase rollover from 0 to 5 (negative rate) during a slot makes the next slot's `rd_addr` two above the previous one. `addr_skipped` is high for that next slot.
- R7: Without a rollover, `rd_addr` rises by one, modulo 2^16, at each slot boundary. It never changes inside a slot.
- R8: With a zero rate, the phase never moves and the address steps by one every slot.
- R9: `init_delay`, `delay_rate` and `start_addr` have an effect only on the start edge. Changing them later does not alter any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start pulse, loads the values and begins tracking |
| init_delay | input | 32 | Initial delay: phase in bits 31:29, fraction in bits 28:0 |
| delay_rate | input | 18 | Signed drift added each clock |
| start_addr | input | 16 | First word address |
| rd_addr | output | 16 | Word address for the current slot |
| load_stb | output | 1 | Load strobe for the output shift register |
| fine_phase | output | 3 | Strobe offset within the current slot (0..5) |
| addr_held | output | 1 | The current slot repeats the previous address |
| addr_skipped | output | 1 | The current slot jumped two words |
| tracking | output | 1 | Tracking is active |

## Verification
The hardest states to reach are the two phase rollovers. With the largest legal rate, a carry out of the 29-bit fraction takes about four thousand clocks, and six carries are needed to roll the phase. The stimulus gets there by loading a fraction within one rate step of its boundary, with the phase already at 5 or 0, so a rollover happens at the first accumulation edge. Two long runs from neutral starting points then reach a rollover by plain accumulation. A bench model computes phase and coarse offset in closed form from the start time, and every cycle's strobe and address are compared against it.

// File: rtl/delay_track_pkg.sv
package delay_track_pkg;

  // How the word address moves at a slot boundary
  typedef enum logic [1:0] {
    ADJ_STEP = 2'd0,
    ADJ_HOLD = 2'd1,
    ADJ_SKIP = 2'd2
  } addr_adj_e;

endpackage

// File: rtl/dly_phase_accum.sv
module dly_phase_accum #(
  parameter int DELAY_W = 32,
  parameter int RATE_W  = 18,
  parameter int PH_W    = 3,
  parameter int SLOTS   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic [DELAY_W-1:0] init_delay,
  input  logic [RATE_W-1:0]  rate_in,
  output logic [PH_W-1:0]    phase_d,
  output logic               wrap,
  output logic               rate_neg
);
  localparam int FRAC_W = DELAY_W - PH_W;
  localparam int EXT_W  = FRAC_W + 1;

  logic [FRAC_W-1:0] frac_q;
  logic [PH_W-1:0]   phase_q;
  logic [RATE_W-1:0] rate_q;
  logic [EXT_W-1:0]  sum;
  logic [PH_W-1:0]   init_field;
  logic [PH_W-1:0]   init_ph;
  logic              step;

  assign rate_neg   = rate_q[RATE_W-1];
  assign init_field = init_delay[DELAY_W-1 -: PH_W];
  assign init_ph    = (init_field >= PH_W'(SLOTS)) ? (init_field - PH_W'(SLOTS)) : init_field;

  // Fraction plus sign-extended rate; top bit flags carry or borrow
  assign sum  = {1'b0, frac_q} + {{(EXT_W - RATE_W){rate_q[RATE_W-1]}}, rate_q};
  assign step = advance & sum[FRAC_W];

  always_comb begin
    phase_d = phase_q;
    wrap    = 1'b0;
    if (load) begin
      phase_d = init_ph;
    end else if (step) begin
      if (!rate_neg) begin
        if (phase_q == PH_W'(SLOTS - 1)) begin
          phase_d = '0;
          wrap    = 1'b1;
        end else begin
          phase_d = phase_q + PH_W'(1);
        end
      end else begin
        if (phase_q == '0) begin
          phase_d = PH_W'(SLOTS - 1);
          wrap    = 1'b1;
        end else begin
          phase_d = phase_q - PH_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= '0;
      phase_q <= '0;
      rate_q  <= '0;
    end else if (load) begin
      frac_q  <= init_delay[FRAC_W-1:0];
      phase_q <= phase_d;
      rate_q  <= rate_in;
    end else if (advance) begin
      frac_q  <= sum[FRAC_W-1:0];
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/dly_slot_timer.sv
module dly_slot_timer #(
  parameter int PH_W  = 3,
  parameter int SLOTS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            advance,
  input  logic            active,
  input  logic [PH_W-1:0] phase_d,
  output logic            strobe,
  output logic            slot_end,
  output logic [PH_W-1:0] slot_phase
);
  localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [CNT_W-1:0] pos_q;
  logic [PH_W-1:0]  sp_q;

  assign slot_end   = advance & (pos_q == CNT_W'(SLOTS - 1));
  assign strobe     = active & (32'(pos_q) == 32'(sp_q));
  assign slot_phase = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sp_q  <= '0;
    end else if (load) begin
      pos_q <= '0;
      sp_q  <= phase_d;
    end else if (advance) begin
      if (slot_end) begin
        pos_q <= '0;
        sp_q  <= phase_d;   // phase as it stands at the new slot's start
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dly_addr_step.sv
module dly_addr_step
  import delay_track_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              slot_end,
  input  logic              wrap,
  input  logic              rate_neg,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              held,
  output logic              skipped
);
  logic      pend_q;
  logic      wrap_any;
  addr_adj_e adj;

  assign wrap_any = pend_q | wrap;

  always_comb begin
    adj = ADJ_STEP;
    if (wrap_any) adj = rate_neg ? ADJ_SKIP : ADJ_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      pend_q  <= 1'b0;
      held    <= 1'b0;
      skipped <= 1'b0;
    end else if (load) begin
      rd_addr <= start_addr;
      pend_q  <= 1'b0;
      held    <= 1'b0;
      skipped <= 1'b0;
    end else if (advance) begin
      if (slot_end) begin
        case (adj)
          ADJ_HOLD: rd_addr <= rd_addr;
          ADJ_SKIP: rd_addr <= rd_addr + ADDR_W'(2);
          default:  rd_addr <= rd_addr + ADDR_W'(1);
        endcase
        held    <= (adj == ADJ_HOLD);
        skipped <= (adj == ADJ_SKIP);
        pend_q  <= 1'b0;
      end else begin
        pend_q <= wrap_any;
      end
    end
  end

endmodule

// File: rtl/delay_tracker.sv
module delay_tracker #(
  parameter int ADDR_W  = 16,
  parameter int DELAY_W = 32,
  parameter int RATE_W  = 18,
  parameter int PH_W    = 3,
  parameter int SLOTS   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [DELAY_W-1:0] init_delay,
  input  logic [RATE_W-1:0]  delay_rate,
  input  logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               load_stb,
  output logic [PH_W-1:0]    fine_phase,
  output logic               addr_held,
  output logic               addr_skipped,
  output logic               tracking
);
  logic            running_q;
  logic            advance;
  logic [PH_W-1:0] phase_d;
  logic            wrap;
  logic            rate_neg;
  logic            slot_end;

  assign advance  = running_q & ~frame_start;
  assign tracking = running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           running_q <= 1'b0;
    else if (frame_start) running_q <= 1'b1;
  end

  dly_phase_accum #(
    .DELAY_W(DELAY_W), .RATE_W(RATE_W), .PH_W(PH_W), .SLOTS(SLOTS)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .advance(advance),
    .init_delay(init_delay), .rate_in(delay_rate),
    .phase_d(phase_d), .wrap(wrap), .rate_neg(rate_neg)
  );

  dly_slot_timer #(
    .PH_W(PH_W), .SLOTS(SLOTS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .advance(advance),
    .active(running_q), .phase_d(phase_d),
    .strobe(load_stb), .slot_end(slot_end), .slot_phase(fine_phase)
  );

  dly_addr_step #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .advance(advance),
    .slot_end(slot_end), .wrap(wrap), .rate_neg(rate_neg),
    .start_addr(start_addr), .rd_addr(rd_addr),
    .held(addr_held), .skipped(addr_skipped)
  );

endmodule

// File: rtl/delay_tracker_chk.sv
module delay_tracker_chk #(
  parameter int ADDR_W = 16,
  parameter int PH_W   = 3,
  parameter int SLOTS  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              load_stb,
  input logic [PH_W-1:0]   fine_phase,
  input logic              addr_held,
  input logic              addr_skipped,
  input logic              tracking,
  input logic              slot_end,
  input logic              rate_neg
);
  logic [1:0] stb_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stb_cnt <= '0;
    else if (frame_start || slot_end) stb_cnt <= '0;
    else if (load_stb)                stb_cnt <= stb_cnt + 2'd1;
  end

  // R4
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> ((stb_cnt + 2'(load_stb)) == 2'd1));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fine_phase) < SLOTS);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tracking |-> (!load_stb && !addr_held && !addr_skipped));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tracking && rd_addr == $past(start_addr) && !addr_held && !addr_skipped));

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (!addr_held || rd_addr == $past(rd_addr)));

  // R5
  hold_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_held |-> !rate_neg);

  // R6
  skip_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (!addr_skipped || rd_addr == $past(rd_addr) + ADDR_W'(2)));

  // R6
  skip_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_skipped |-> rate_neg);

  // R7
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (addr_held || addr_skipped || rd_addr == $past(rd_addr) + ADDR_W'(1)));

  // R7
  steady_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && !slot_end && !frame_start) |=> $stable(rd_addr));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_held && addr_skipped));

endmodule

bind delay_tracker delay_tracker_chk #(
  .ADDR_W(ADDR_W), .PH_W(PH_W), .SLOTS(SLOTS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start_addr(start_addr),
  .rd_addr(rd_addr), .load_stb(load_stb), .fine_phase(fine_phase),
  .addr_held(addr_held), .addr_skipped(addr_skipped), .tracking(tracking),
  .slot_end(slot_end), .rate_neg(rate_neg)
);

// File: tb/delay_tracker_tb_top.sv
module delay_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] init_delay = '0;
  logic [17:0] delay_rate = '0;
  logic [15:0] start_addr = '0;
  logic [15:0] rd_addr;
  logic        load_stb;
  logic [2:0]  fine_phase;
  logic        addr_held;
  logic        addr_skipped;
  logic        tracking;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  delay_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .init_delay(init_delay),
    .delay_rate(delay_rate), .start_addr(start_addr), .rd_addr(rd_addr),
    .load_stb(load_stb), .fine_phase(fine_phase), .addr_held(addr_held),
    .addr_skipped(addr_skipped), .tracking(tracking)
  );

  // Stimulus: start value, rate, address, run length.
  // Expected: held slots, skipped slots, phase of the last slot, tag.
  localparam int NV = 7;
  localparam logic [31:0] VEC_INIT [NV] = '{
    {3'd5, 29'h1FFFFF9C}, {3'd0, 29'd50}, {3'd2, 29'd0}, {3'd7, 29'h1FFFFFFF},
    {3'd6, 29'd1}, {3'd3, 29'd0}, {3'd1, 29'h10000000}};
  localparam logic signed [17:0] VEC_RATE [NV] = '{
    18'sh1FFFF, 18'sh20000, 18'sh00000, 18'sh00001, 18'sh3FFFE, 18'sh1FFFF, 18'sh27960};
  localparam logic [15:0] VEC_ADDR [NV] = '{
    16'h0100, 16'h2000, 16'hFFFE, 16'h0005, 16'h0040, 16'h1234, 16'h8000};
  localparam int VEC_LEN  [NV] = '{60, 60, 30, 30, 30, 30000, 20000};
  localparam int EXP_HELD [NV] = '{1, 0, 0, 0, 0, 1, 0};
  localparam int EXP_SKIP [NV] = '{0, 1, 0, 0, 1, 0, 1};
  localparam int EXP_PH   [NV] = '{0, 5, 2, 2, 5, 4, 3};
  localparam string VEC_TAG [NV] = '{"R5", "R6", "R8", "R9", "R6", "R5", "R6"};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic run_vector(input int v);
    longint base, rate_l, e, f, ph, co, prev_co;
    int held_obs, skip_obs, slot_ph, last_ph;
    logic [15:0] exp_addr;
    held_obs = 0; skip_obs = 0; slot_ph = 0; last_ph = 0; prev_co = 0; exp_addr = '0;
    @(negedge clk);
    frame_start = 1'b1;
    init_delay  = VEC_INIT[v];
    delay_rate  = VEC_RATE[v];
    start_addr  = VEC_ADDR[v];
    @(negedge clk);
    frame_start = 1'b0;
    // R9: scramble the captured inputs after the start edge
    init_delay  = ~VEC_INIT[v];
    delay_rate  = ~VEC_RATE[v];
    start_addr  = ~VEC_ADDR[v];
    rate_l = longint'(VEC_RATE[v]);
    base   = (longint'(int'(VEC_INIT[v][31:29]) % 6) <<< 29) + longint'(VEC_INIT[v][28:0]);
    chk(tracking == 1'b1 && rd_addr == VEC_ADDR[v], "R2", longint'(rd_addr), longint'(VEC_ADDR[v]));
    for (int j = 0; j < VEC_LEN[v]; j++) begin
      if (j % 6 == 0) begin
        e  = base + longint'(j) * rate_l;
        f  = e >>> 29;
        ph = f % 6;
        if (ph < 0) ph = ph + 6;
        co = (f - ph) / 6;
        slot_ph  = int'(ph);
        exp_addr = VEC_ADDR[v] + 16'(j / 6) - 16'(co);
        if (j > 0) begin
          chk(addr_held == (co > prev_co), "R5", longint'(addr_held), longint'(co > prev_co));
          chk(addr_skipped == (co < prev_co), "R6", longint'(addr_skipped), longint'(co < prev_co));
          if (addr_held) held_obs++;
          if (addr_skipped) skip_obs++;
        end
        prev_co = co;
        chk(int'(fine_phase) == slot_ph, "R3", longint'(fine_phase), longint'(slot_ph));
        last_ph = int'(fine_phase);
      end
      chk(load_stb == (j % 6 == slot_ph), "R4", longint'(load_stb), longint'(j % 6 == slot_ph));
      if (j % 6 == slot_ph)
        chk(rd_addr == exp_addr, "R7", longint'(rd_addr), longint'(exp_addr));
      @(negedge clk);
    end
    chk(held_obs == EXP_HELD[v], VEC_TAG[v], longint'(held_obs), longint'(EXP_HELD[v]));
    chk(skip_obs == EXP_SKIP[v], VEC_TAG[v], longint'(skip_obs), longint'(EXP_SKIP[v]));
    chk(last_ph == EXP_PH[v], VEC_TAG[v], longint'(last_ph), longint'(EXP_PH[v]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, inputs moving but no start pulse
    init_delay = 32'hFFFF_FFFF;
    delay_rate = 18'h1FFFF;
    start_addr = 16'hABCD;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!tracking && !load_stb && rd_addr == 16'h0 && fine_phase == 3'd0 &&
          !addr_held && !addr_skipped, "R1", longint'(rd_addr), 0);
    end

    for (int v = 0; v < NV; v++) run_vector(v);

    // R2: restart mid-slot while tracking
    @(negedge clk);
    frame_start = 1'b1;
    init_delay  = {3'd4, 29'd0};
    delay_rate  = 18'h0;
    start_addr  = 16'h0777;
    @(negedge clk);
    frame_start = 1'b0;
    chk(rd_addr == 16'h0777 && fine_phase == 3'd4 && !addr_held && !addr_skipped,
        "R2", longint'(rd_addr), longint'(16'h0777));
    repeat (4) @(negedge clk);
    chk(load_stb == 1'b1, "R4", longint'(load_stb), 1);

    // R1: reset in the middle of tracking returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tracking && !load_stb && rd_addr == 16'h0, "R1", longint'(tracking), 0);

    summary();
    $finish;
  end

endmodule